// File: doc/BRIEF.md
# Dual Down-Counting Timer with Shared Prescaler

The block contains two down-counting timers. Both are driven by one programmable prescaler. The prescaler counts system clocks down. Each time it passes through zero it reloads from its own reload word and emits a single-cycle tick. Each enabled timer steps down by one on every tick.

When a timer is at zero on a tick, it raises its interrupt line for one clock. Its mode bit then selects what happens next:
- In reload mode, the timer reloads from its reload word and keeps counting.
- In stop mode, the timer clears its own enable and stays at zero.

Software drives the block through a word-addressed register port that is written in one cycle. Reads are combinational. A load-now strobe in each control word copies the reload word into the counter without waiting for a tick.

Top module: `dual_tick_timer`

## Requirements
- R1: Word addresses are fixed as follows:
  - 0, 1 and 2: timer A counter, reload and control.
  - 3: a spare 32-bit storage word.
  - 4, 5 and 6: timer B counter, reload and control.
  - 7: an unused word.
  - 8 and 9: prescaler counter and prescaler reload.
  - Counter and reload words hold CNT_W bits (16 by default). Wider write data is truncated.
- R2: The prescaler runs while at least one timer is enabled. Each clock it steps down by one. When it is zero it reloads from the prescaler reload word and issues one tick, so a tick occurs every reload+1 clocks. When both timers are disabled, the prescaler holds its value.
- R3: Control bit 0 is the enable. An enabled timer decrements once per tick. With bit 0 clear, the counter holds its value.
- R4: Writing a control word with bit 2 set copies the reload word into the counter at once. With bit 2 clear, the write leaves the counter untouched.
- R5: A control word reads back bit 1 (reload mode) and bit 0 (enable). All other bits, including bit 2, read as 0.
- R6: In stop mode (bit 1 = 0), a tick that finds the counter at zero does three things:
  - It raises the interrupt.
  - It clears the enable bit.
  - It leaves the counter at 0.
- R7: In reload mode (bit 1 = 1), a tick at zero raises the interrupt and reloads the counter, and counting continues. The interrupt period is reload+1 ticks.
- R8: The interrupt of timer A appears on irq_a and that of timer B on irq_b. Each is high only in the clock after the underflow tick, and only for a timer that was enabled.
- R9: A bus write landing in the same cycle as an underflow takes priority for the words it writes. The interrupt for that underflow is still raised.
- R10: The spare word stores any 32-bit value. The unused word and addresses 10 to 15 read 0 and ignore writes.
- R11: After reset, every word reads 0 and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W (4) | Word address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for addr, combinational |
| irq_a | output | 1 | Timer A underflow pulse |
| irq_b | output | 1 | Timer B underflow pulse |

## Verification
Two things can land in one clock:
- a timer underflow, where the tick finds the counter at zero;
- a software write to that timer's control word carrying the load-now strobe.

The bench provokes this with a prescaler reload of 0, so a tick fires every clock. It counts the clocks after a stop-mode start and issues the write exactly on the edge where the counter sits at zero. It judges the outcome from three observations:
- the interrupt still pulses;
- the enable written by software survives the stop-mode clear;
- the counter holds the reload value and decrements again on the next tick.

// File: rtl/dual_tick_timer.sv
module dual_tick_timer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_a,
  output logic              irq_b
);
  localparam logic [ADDR_W-1:0] A_SPARE = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PCNT  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_PRLD  = ADDR_W'(9);

  logic [PRE_W-1:0]  scal, scal_rld;
  logic [DATA_W-1:0] spare;
  logic [1:0]        en_w, rl_w, irq_w;
  logic [CNT_W-1:0]  cnt_w [2];
  logic [CNT_W-1:0]  rld_w [2];

  wire run  = |en_w;
  wire tick = run && (scal == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scal     <= '0;
      scal_rld <= '0;
      spare    <= '0;
    end else begin
      if (wr_en && addr == A_PRLD)  scal_rld <= wdata[PRE_W-1:0];
      if (wr_en && addr == A_SPARE) spare    <= wdata;
      if (wr_en && addr == A_PCNT)  scal     <= wdata[PRE_W-1:0];
      else if (run)                 scal     <= (scal == '0) ? scal_rld : scal - 1'b1;
    end
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_tmr
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(4*gi);
    localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(4*gi + 1);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(4*gi + 2);

    logic [CNT_W-1:0] cnt, rld;
    logic             en, rl, irq;

    wire w_cnt = wr_en && addr == A_CNT;
    wire w_rld = wr_en && addr == A_RLD;
    wire w_ctl = wr_en && addr == A_CTL;
    wire under = tick && en && (cnt == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        rld <= '0;
        en  <= 1'b0;
        rl  <= 1'b0;
        irq <= 1'b0;
      end else begin
        if (w_rld) rld <= wdata[CNT_W-1:0];
        if (w_cnt)                  cnt <= wdata[CNT_W-1:0];
        else if (w_ctl && wdata[2]) cnt <= rld;
        else if (tick && en)        cnt <= (cnt != '0) ? cnt - 1'b1 : (rl ? rld : cnt);
        if (w_ctl) begin
          en <= wdata[0];
          rl <= wdata[1];
        end else if (under && !rl) begin
          en <= 1'b0;
        end
        irq <= under;
      end
    end

    assign cnt_w[gi] = cnt;
    assign rld_w[gi] = rld;
    assign en_w[gi]  = en;
    assign rl_w[gi]  = rl;
    assign irq_w[gi] = irq;
  end

  assign irq_a = irq_w[0];
  assign irq_b = irq_w[1];

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(0): rdata = DATA_W'(cnt_w[0]);
      ADDR_W'(1): rdata = DATA_W'(rld_w[0]);
      ADDR_W'(2): rdata = DATA_W'({rl_w[0], en_w[0]});
      A_SPARE:    rdata = spare;
      ADDR_W'(4): rdata = DATA_W'(cnt_w[1]);
      ADDR_W'(5): rdata = DATA_W'(rld_w[1]);
      ADDR_W'(6): rdata = DATA_W'({rl_w[1], en_w[1]});
      A_PCNT:     rdata = DATA_W'(scal);
      A_PRLD:     rdata = DATA_W'(scal_rld);
      default:    rdata = '0;
    endcase
  end
endmodule

module dual_tick_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr,
  input logic             irq_a,
  input logic             irq_b,
  input logic [1:0]       en,
  input logic [1:0]       rl,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic [PRE_W-1:0] scal
);
  AST_SCALER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (en == 2'b00 && !wr) |=> $stable(scal)); // R2
  AST_CNT_A_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!en[0] && !wr) |=> $stable(cnt0)); // R3
  AST_CNT_B_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!en[1] && !wr) |=> $stable(cnt1)); // R3
  AST_STOP_DISARMS_A: assert property (@(posedge clk) disable iff (!rst_n) (irq_a && !$past(rl[0]) && !$past(wr)) |-> !en[0]); // R6
  AST_STOP_DISARMS_B: assert property (@(posedge clk) disable iff (!rst_n) (irq_b && !$past(rl[1]) && !$past(wr)) |-> !en[1]); // R6
  AST_IRQ_A_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) irq_a |-> ($past(cnt0) == '0)); // R8
  AST_IRQ_B_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) irq_b |-> ($past(cnt1) == '0)); // R8
  AST_IRQ_A_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) !en[0] |=> !irq_a); // R8
  AST_IRQ_B_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) !en[1] |=> !irq_b); // R8
endmodule

bind dual_tick_timer dual_tick_timer_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr_en), .irq_a(irq_a), .irq_b(irq_b),
  .en(en_w), .rl(rl_w), .cnt0(cnt_w[0]), .cnt1(cnt_w[1]), .scal(scal)
);

// File: tb/dual_tick_timer_tb.sv
module dual_tick_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 27;

  // vector: {is_read, addr[3:0], data[31:0]}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b0, 4'd1,  32'd5},        // R1 timer A reload
    {1'b1, 4'd1,  32'd5},
    {1'b0, 4'd0,  32'h12345},    // R1 truncation
    {1'b1, 4'd0,  32'h2345},
    {1'b0, 4'd0,  32'd7},
    {1'b0, 4'd2,  32'd0},        // R4 zero strobe
    {1'b1, 4'd0,  32'd7},
    {1'b0, 4'd2,  32'd4},        // R4 load now
    {1'b1, 4'd0,  32'd5},
    {1'b1, 4'd2,  32'd0},        // R5
    {1'b0, 4'd2,  32'hFFFFFFFA},
    {1'b1, 4'd2,  32'd2},        // R5 upper bits dropped
    {1'b0, 4'd2,  32'd0},
    {1'b0, 4'd3,  32'hBEEF},     // R10 spare
    {1'b1, 4'd3,  32'hBEEF},
    {1'b0, 4'd7,  32'h1234},     // R10 unused
    {1'b1, 4'd7,  32'd0},
    {1'b1, 4'd12, 32'd0},
    {1'b0, 4'd5,  32'h22},       // R1 timer B reload
    {1'b1, 4'd5,  32'h22},
    {1'b0, 4'd9,  32'd3},        // R1 prescaler reload
    {1'b1, 4'd9,  32'd3},
    {1'b1, 4'd8,  32'd0},        // R2 held while idle
    {1'b0, 4'd6,  32'd2},
    {1'b1, 4'd6,  32'd2},
    {1'b0, 4'd6,  32'd0},
    {1'b1, 4'd4,  32'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_a, irq_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    chk(rdata, exp, req);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    for (int a = 0; a < 10; a++) rd(4'(a), 32'd0, "R11");
    chk({31'd0, irq_a}, 0, "R11 irq_a");
    chk({31'd0, irq_b}, 0, "R11 irq_b");

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][36]) rd(VEC[i][35:32], VEC[i][31:0], "R1/R4/R5/R10 vector");
      else wr(VEC[i][35:32], VEC[i][31:0]);
    end

    // R6 stop mode, prescaler reload 0 -> tick each clock
    wr(4'd9, 0);
    wr(4'd1, 3);
    wr(4'd2, 5);
    rd(4'd0, 3, "R4 load at start");
    step(); rd(4'd0, 2, "R3 decrement");
    step(); step(); rd(4'd0, 0, "R3 reached zero");
    chk({31'd0, irq_a}, 0, "R8 no early irq");
    step();
    chk({31'd0, irq_a}, 1, "R6 irq_a pulse");
    chk({31'd0, irq_b}, 0, "R8 irq_b quiet");
    rd(4'd2, 0, "R6 enable cleared");
    rd(4'd0, 0, "R6 counter stays zero");
    step();
    chk({31'd0, irq_a}, 0, "R8 one-cycle pulse");
    rd(4'd0, 0, "R6 counter still zero");

    // R7 reload mode on timer B
    wr(4'd5, 2);
    wr(4'd6, 7);
    rd(4'd4, 2, "R7 start");
    step(); step(); rd(4'd4, 0, "R7 at zero");
    step();
    chk({31'd0, irq_b}, 1, "R7 irq_b pulse");
    chk({31'd0, irq_a}, 0, "R8 irq_a quiet");
    rd(4'd4, 2, "R7 reloaded");
    rd(4'd6, 3, "R7 still enabled");
    step();
    chk({31'd0, irq_b}, 0, "R8 irq_b one cycle");
    rd(4'd4, 1, "R7 keeps counting");
    wr(4'd6, 0);

    // R2 prescaler divides by reload+1
    wr(4'd9, 3);
    wr(4'd8, 3);
    wr(4'd1, 1);
    wr(4'd2, 5);
    rd(4'd8, 3, "R2 held before run");
    step(); rd(4'd8, 2, "R2 prescaler counts");
    step(); step(); rd(4'd0, 1, "R2 no tick yet");
    step(); rd(4'd0, 0, "R2 first tick");
    rd(4'd8, 3, "R2 prescaler reloaded");
    step(); step(); step();
    chk({31'd0, irq_a}, 0, "R2 irq waits for tick");
    step();
    chk({31'd0, irq_a}, 1, "R2 irq on second tick");
    step(); rd(4'd8, 3, "R2 idle hold");
    step(); rd(4'd8, 3, "R2 idle hold again");

    // R3 disable holds counter
    wr(4'd9, 0);
    wr(4'd8, 0);
    wr(4'd1, 9);
    wr(4'd2, 7);
    step(); step();
    wr(4'd2, 2);
    step(); step(); step();
    rd(4'd0, 6, "R3 disabled hold");
    rd(4'd2, 2, "R5 mode kept");

    // R9 load-now write on the underflow edge
    wr(4'd1, 2);
    wr(4'd2, 5);
    step(); step();
    rd(4'd0, 0, "R9 setup at zero");
    wr(4'd2, 5);
    chk({31'd0, irq_a}, 1, "R9 irq still raised");
    rd(4'd2, 1, "R9 write enable wins");
    rd(4'd0, 2, "R9 load wins");
    step();
    chk({31'd0, irq_a}, 0, "R9 pulse ends");
    rd(4'd0, 1, "R9 counting resumes");
    wr(4'd2, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule